// File: doc/BRIEF.md
# LCD Controller Run Control

This block holds the control state of a simple parallel-LCD framebuffer controller and sequences its start and stop. Software reaches four registers through a small write/read port. Each writable register can be written in three ways, chosen by the two low address bits. A plain write replaces the register. A set write ORs the data into it. A clear write removes the bits that are 1 in the data. The block holds the fetch-engine run flag, the dot-clock mode flag, the sync-output enable, three sync polarity bits, a self-clearing FIFO flush request, a frame-done interrupt enable and status, and a shadowed pair of framebuffer base addresses.

Starting the display takes three separate steps: enable dot-clock mode, then enable the sync outputs, then request run. Stopping is graceful. Software drops dot-clock mode, and the run flag stays set until the pixel FIFO reports empty. Software writes the next framebuffer base at any time. The fetch engine sees the new base only at a frame boundary. At that boundary the frame-done status also rises. The fetch engine and the timing generator are outside this block. They appear here as a FIFO-empty level, a frame-end pulse and three raw timing lines.

Register map. Address bits [3:2] select the register: 0 control, 1 interrupt, 2 next base, 3 current base (read-only). Address bits [1:0] select the write kind: 0 plain, 1 set, 2 clear, 3 no write. Control register bits: [0] run, [1] dot-clock mode, [2] sync enable, [3] FIFO flush (reads 0), [4] hsync active-high, [5] vsync active-high, [6] data-enable active-high. Interrupt register bits: [0] enable, [1] frame-done status.

Top module: `lcd_run_ctrl`

## Requirements
- R1: A plain write stores the data. A set write ORs the data into the register. A clear write clears the bits that are 1 in the data. Write kind 3 changes nothing. `reg_rdata` shows the register selected by `reg_addr[3:2]` with no cycle of delay.
- R2: A write that requests run (control bit 0 resulting as 1) starts the fetch engine only if dot-clock mode and sync enable were already 1 before that write. Otherwise run stays 0.
- R3: A write cannot clear run. Once run is 1, it falls on the first clock edge at which dot-clock mode is 0 and `fifo_empty` is 1. Run stays 1 while `fifo_empty` is 0.
- R4: A plain or set write with control bit 3 at 1 raises `fifo_flush` for exactly the following cycle. Control bit 3 always reads back 0.
- R5: A `frame_end` pulse while run is 1 copies the next base into the current base and sets frame-done status at the next edge. While run is 0, `frame_end` changes nothing.
- R6: `frame_irq` is 1 exactly when frame-done status and its enable are both 1.
- R7: Frame-done status is cleared only by a clear-kind write with interrupt bit 1 at 1. Plain and set writes leave it alone. A `frame_end` in the same cycle wins over the clear.
- R8: Each LCD sync line shows its active level (bit 4/5/6 set means active-high) only when run, sync enable and its timing input are all 1. Otherwise it shows its inactive level.
- R9: After reset every register is 0. `fetch_en`, `fifo_flush` and `frame_irq` are 0, and the sync lines sit at the active-low inactive level 1.
- R10: `fetch_en` equals the run flag and `fetch_base` equals the current base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 4 | Register select [3:2], write kind [1:0] |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| fifo_empty | input | 1 | Pixel FIFO is empty |
| frame_end | input | 1 | One-cycle pulse at the end of a frame |
| tg_hsync | input | 1 | Raw horizontal sync from the timing generator |
| tg_vsync | input | 1 | Raw vertical sync from the timing generator |
| tg_de | input | 1 | Raw data enable from the timing generator |
| fetch_en | output | 1 | Run flag for the fetch engine |
| fetch_base | output | DATA_W | Framebuffer base in use |
| fifo_flush | output | 1 | One-cycle FIFO flush request |
| frame_irq | output | 1 | Frame-done interrupt |
| lcd_hsync | output | 1 | Horizontal sync to the panel |
| lcd_vsync | output | 1 | Vertical sync to the panel |
| lcd_de | output | 1 | Data enable to the panel |

## Verification
Writes and `frame_end` pulses act at the next rising edge. From that edge on, `fetch_en`, `fetch_base`, `frame_irq`, `fifo_flush` and the register contents show the result. `reg_rdata` and the three LCD lines follow `reg_addr` and the timing inputs within the same cycle. The bench drives every input 1 ns after a rising edge. A behavioural model advances at each rising edge, and the bench compares all outputs with it at the following falling edge. Each result is therefore checked in the cycle it is due.

// File: rtl/lcdrc_pkg.sv
// Shared definitions of the LCD run control: register selects, write
// kinds, control bit positions and the per-bit write-kind rule.
package lcdrc_pkg;
    localparam int ADDR_W    = 4;
    localparam int CTRL_BITS = 7;
    localparam int IRQ_BITS  = 2;
    localparam int SYNC_LINES = 3;

    typedef enum logic [1:0] {
        AL_PLAIN = 2'd0,
        AL_SET   = 2'd1,
        AL_CLR   = 2'd2,
        AL_NONE  = 2'd3
    } alias_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_IRQ  = 2'd1;
    localparam logic [1:0] SEL_NEXT = 2'd2;
    localparam logic [1:0] SEL_CUR  = 2'd3;

    localparam int CB_RUN   = 0;
    localparam int CB_DOT   = 1;
    localparam int CB_SYNC  = 2;
    localparam int CB_FLUSH = 3;
    localparam int CB_POL   = 4;

    localparam int IB_EN = 0;
    localparam int IB_ST = 1;

    // New value of one register bit under a given write kind.
    function automatic logic alias_bit(input logic old_v, input logic data_v,
                                       input alias_e kind);
        logic r;
        unique case (kind)
            AL_PLAIN: r = data_v;
            AL_SET:   r = old_v | data_v;
            AL_CLR:   r = old_v & ~data_v;
            default:  r = old_v;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/lcdrc_regif.sv
// Register port decode and read multiplexer.
// Turns a write into a per-register strobe and a write kind. Returns the
// selected register on the read bus in the same cycle.
// Assumes DATA_W is at least CTRL_BITS wide.
module lcdrc_regif
    import lcdrc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [CTRL_BITS-1:0] ctrl_word,
    input  logic [IRQ_BITS-1:0]  irq_word,
    input  logic [DATA_W-1:0]    next_word,
    input  logic [DATA_W-1:0]    cur_word,
    output logic                 wr_ctrl,
    output logic                 wr_irq,
    output logic                 wr_next,
    output alias_e               kind,
    output logic [DATA_W-1:0]    rdata
);
    logic [1:0] sel;
    logic       wr_any;

    // Split the address into register select and write kind.
    always_comb begin
        sel    = reg_addr[3:2];
        kind   = alias_e'(reg_addr[1:0]);
        wr_any = reg_wr && (kind != AL_NONE);
    end

    // One strobe per writable register; the current base has none.
    always_comb begin
        wr_ctrl = wr_any && (sel == SEL_CTRL);
        wr_irq  = wr_any && (sel == SEL_IRQ);
        wr_next = wr_any && (sel == SEL_NEXT);
    end

    // Read multiplexer, zero-extended to the bus width.
    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_CTRL: rdata[CTRL_BITS-1:0] = ctrl_word;
            SEL_IRQ:  rdata[IRQ_BITS-1:0]  = irq_word;
            SEL_NEXT: rdata = next_word;
            default:  rdata = cur_word;
        endcase
    end
endmodule

// File: rtl/lcdrc_seq.sv
// Run/stop sequencer and control register.
// Holds dot-clock mode, sync enable, polarities and the run flag. Run only
// starts when dot-clock mode and sync enable are already on. Writes never
// clear run. Run falls once dot-clock mode is off and the FIFO is empty.
// A flush request becomes a one-cycle pulse.
// Assumes fifo_empty is synchronous to clk.
module lcdrc_seq
    import lcdrc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_ctrl,
    input  alias_e                kind,
    input  logic [CTRL_BITS-1:0]  wbits,
    input  logic                  fifo_empty,
    output logic                  run_o,
    output logic                  sync_o,
    output logic [SYNC_LINES-1:0] pol_o,
    output logic                  flush_o,
    output logic [CTRL_BITS-1:0]  ctrl_word
);
    logic                  run_q, dot_q, sync_q, flush_q;
    logic [SYNC_LINES-1:0] pol_q;
    logic [CTRL_BITS-1:0]  nbits;
    logic                  drain_done, start_ok;

    // Readback image; the flush bit always reads 0.
    always_comb ctrl_word = {pol_q, 1'b0, sync_q, dot_q, run_q};

    // Per-bit result of the write kind applied to the stored word.
    always_comb begin
        for (int i = 0; i < CTRL_BITS; i++)
            nbits[i] = alias_bit(ctrl_word[i], wbits[i], kind);
    end

    // Stop and start conditions of the fetch engine.
    always_comb begin
        drain_done = run_q & ~dot_q & fifo_empty;
        start_ok   = ~run_q & wr_ctrl & nbits[CB_RUN] & dot_q & sync_q;
    end

    // Control register, run flag and flush pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            dot_q   <= 1'b0;
            sync_q  <= 1'b0;
            pol_q   <= '0;
            flush_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                dot_q  <= nbits[CB_DOT];
                sync_q <= nbits[CB_SYNC];
                pol_q  <= nbits[CB_POL +: SYNC_LINES];
            end
            flush_q <= wr_ctrl & nbits[CB_FLUSH];
            if (drain_done)
                run_q <= 1'b0;
            else if (start_ok)
                run_q <= 1'b1;
        end
    end

    always_comb begin
        run_o   = run_q;
        sync_o  = sync_q;
        pol_o   = pol_q;
        flush_o = flush_q;
    end

    assert_run_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> $past(dot_q && sync_q));
    assert_run_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q && !fifo_empty |=> run_q);
    assert_run_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> $past(!dot_q && fifo_empty));
    assert_flush_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_q |-> $past(wr_ctrl && wbits[CB_FLUSH] && kind != AL_CLR));
endmodule

// File: rtl/lcdrc_bufshadow.sv
// Framebuffer base shadow and frame-done interrupt.
// Software writes the next base. At a frame end during run, the next base
// moves into the current base and frame-done status is set. Status
// clears only through a clear-kind write; a frame end in the same cycle
// wins. The interrupt is status AND enable.
// Assumes frame_end is a one-cycle pulse synchronous to clk.
module lcdrc_bufshadow
    import lcdrc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_irq,
    input  logic                wr_next,
    input  alias_e              kind,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                frame_end,
    input  logic                run,
    output logic [DATA_W-1:0]   next_o,
    output logic [DATA_W-1:0]   cur_o,
    output logic [IRQ_BITS-1:0] irq_word,
    output logic                irq_o
);
    logic [DATA_W-1:0] next_q, cur_q, next_d;
    logic              en_q, st_q, swap;

    // A frame boundary only counts while the engine runs.
    always_comb swap = frame_end & run;

    // Write-kind result for the next-base register.
    always_comb begin
        for (int i = 0; i < DATA_W; i++)
            next_d[i] = alias_bit(next_q[i], wdata[i], kind);
    end

    // Next base, current base, interrupt enable and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= '0;
            cur_q  <= '0;
            en_q   <= 1'b0;
            st_q   <= 1'b0;
        end else begin
            if (wr_next)
                next_q <= next_d;
            if (swap)
                cur_q <= next_q;
            if (wr_irq)
                en_q <= alias_bit(en_q, wdata[IB_EN], kind);
            if (swap)
                st_q <= 1'b1;
            else if (wr_irq && kind == AL_CLR && wdata[IB_ST])
                st_q <= 1'b0;
        end
    end

    always_comb begin
        next_o   = next_q;
        cur_o    = cur_q;
        irq_word = {st_q, en_q};
        irq_o    = st_q & en_q;
    end

    assert_next_plain_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_next && kind == AL_PLAIN |=> next_q == $past(wdata));
    assert_cur_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end && run |=> cur_q == $past(next_q));
    assert_cur_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_end && run) |=> $stable(cur_q));
    assert_status_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end && run |=> st_q);
    assert_status_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_irq && kind == AL_CLR && wdata[IB_ST] && !(frame_end && run) |=> !st_q);
endmodule

// File: rtl/lcdrc_syncgate.sv
// Sync output gating and polarity.
// Each line shows its active level only while the gate is open and its
// raw timing input is high. Otherwise it shows its inactive level.
// Assumes raw timing inputs are active-high.
module lcdrc_syncgate #(
    parameter int LINES = 3
) (
    input  logic             gate,
    input  logic [LINES-1:0] tg_in,
    input  logic [LINES-1:0] pol,
    output logic [LINES-1:0] lcd_out
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Map the gated raw level onto the selected polarity.
        assign lcd_out[g] = (gate & tg_in[g]) ? pol[g] : ~pol[g];
    end
endmodule

// File: rtl/lcd_run_ctrl.sv
// Top of the LCD run control: register port, run sequencer, base shadow
// and sync gating.
// Assumes every input is synchronous to clk and the reset is synchronous.
module lcd_run_ctrl
    import lcdrc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              fifo_empty,
    input  logic              frame_end,
    input  logic              tg_hsync,
    input  logic              tg_vsync,
    input  logic              tg_de,
    output logic              fetch_en,
    output logic [DATA_W-1:0] fetch_base,
    output logic              fifo_flush,
    output logic              frame_irq,
    output logic              lcd_hsync,
    output logic              lcd_vsync,
    output logic              lcd_de
);
    logic                  wr_ctrl, wr_irq, wr_next;
    alias_e                kind;
    logic [CTRL_BITS-1:0]  ctrl_word;
    logic [IRQ_BITS-1:0]   irq_word;
    logic [DATA_W-1:0]     next_word, cur_word;
    logic                  run, sync_en;
    logic [SYNC_LINES-1:0] pol, lines;

    lcdrc_regif #(.DATA_W(DATA_W)) u_regif (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .ctrl_word (ctrl_word),
        .irq_word  (irq_word),
        .next_word (next_word),
        .cur_word  (cur_word),
        .wr_ctrl   (wr_ctrl),
        .wr_irq    (wr_irq),
        .wr_next   (wr_next),
        .kind      (kind),
        .rdata     (reg_rdata)
    );

    lcdrc_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .kind       (kind),
        .wbits      (reg_wdata[CTRL_BITS-1:0]),
        .fifo_empty (fifo_empty),
        .run_o      (run),
        .sync_o     (sync_en),
        .pol_o      (pol),
        .flush_o    (fifo_flush),
        .ctrl_word  (ctrl_word)
    );

    lcdrc_bufshadow #(.DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_irq    (wr_irq),
        .wr_next   (wr_next),
        .kind      (kind),
        .wdata     (reg_wdata),
        .frame_end (frame_end),
        .run       (run),
        .next_o    (next_word),
        .cur_o     (cur_word),
        .irq_word  (irq_word),
        .irq_o     (frame_irq)
    );

    lcdrc_syncgate #(.LINES(SYNC_LINES)) u_sync (
        .gate    (run & sync_en),
        .tg_in   ({tg_de, tg_vsync, tg_hsync}),
        .pol     (pol),
        .lcd_out (lines)
    );

    // Drive the fetch interface and the panel lines.
    always_comb begin
        fetch_en   = run;
        fetch_base = cur_word;
        {lcd_de, lcd_vsync, lcd_hsync} = lines;
    end
endmodule

// File: tb/lcd_run_ctrl_bench.sv
module lcd_run_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        fifo_empty = 1'b1;
    logic        frame_end = 1'b0;
    logic        tg_hsync = 1'b0, tg_vsync = 1'b0, tg_de = 1'b0;
    logic        fetch_en, fifo_flush, frame_irq;
    logic [31:0] fetch_base;
    logic        lcd_hsync, lcd_vsync, lcd_de;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lcd_run_ctrl u_lcd_run_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_empty(fifo_empty),
        .frame_end(frame_end), .tg_hsync(tg_hsync), .tg_vsync(tg_vsync),
        .tg_de(tg_de), .fetch_en(fetch_en), .fetch_base(fetch_base),
        .fifo_flush(fifo_flush), .frame_irq(frame_irq), .lcd_hsync(lcd_hsync),
        .lcd_vsync(lcd_vsync), .lcd_de(lcd_de)
    );

    // Behavioural reference state
    logic        m_run, m_dot, m_sync, m_flush, m_en, m_st;
    logic [2:0]  m_pol;
    logic [31:0] m_next, m_cur;

    function automatic logic [31:0] apply(logic [31:0] o, logic [31:0] d, logic [1:0] k);
        case (k)
            2'd0: return d;
            2'd1: return o | d;
            2'd2: return o & ~d;
            default: return o;
        endcase
    endfunction

    function automatic logic [31:0] m_rd(logic [1:0] sel);
        case (sel)
            2'd0: return {25'd0, m_pol, 1'b0, m_sync, m_dot, m_run};
            2'd1: return {30'd0, m_st, m_en};
            2'd2: return m_next;
            default: return m_cur;
        endcase
    endfunction

    function automatic logic line_exp(logic raw, logic p, logic g);
        return p ? (g & raw) : !(g & raw);
    endfunction

    // Reference model step at each rising edge
    always @(posedge clk) begin
        logic [31:0] nc, ni;
        logic [1:0]  sel, k;
        logic        wc, wi, wn, sw, n_run;
        if (!rst_n) begin
            m_run = 0; m_dot = 0; m_sync = 0; m_flush = 0; m_en = 0; m_st = 0;
            m_pol = 0; m_next = 0; m_cur = 0;
        end else begin
            sel = reg_addr[3:2];
            k   = reg_addr[1:0];
            wc  = reg_wr && sel == 2'd0 && k != 2'd3;
            wi  = reg_wr && sel == 2'd1 && k != 2'd3;
            wn  = reg_wr && sel == 2'd2 && k != 2'd3;
            sw  = frame_end && m_run;
            nc  = apply({25'd0, m_pol, 1'b0, m_sync, m_dot, m_run}, reg_wdata, k);
            ni  = apply({30'd0, m_st, m_en}, reg_wdata, k);
            if (m_run) n_run = !(!m_dot && fifo_empty);
            else       n_run = wc && nc[0] && m_dot && m_sync;
            m_flush = wc && nc[3];
            if (wc) begin
                m_dot = nc[1]; m_sync = nc[2]; m_pol = nc[6:4];
            end
            if (sw) m_cur = m_next;
            if (wn) m_next = apply(m_next, reg_wdata, k);
            if (wi) m_en = ni[0];
            if (sw) m_st = 1'b1;
            else if (wi && k == 2'd2 && reg_wdata[1]) m_st = 1'b0;
            m_run = n_run;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare every output with the model at each falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R10 fetch_en", 32'(fetch_en), 32'(m_run));
            chk("R10 fetch_base", fetch_base, m_cur);
            chk("R6 frame_irq", 32'(frame_irq), 32'(m_st & m_en));
            chk("R4 fifo_flush", 32'(fifo_flush), 32'(m_flush));
            chk("R8 lcd lines", 32'({lcd_de, lcd_vsync, lcd_hsync}),
                32'({line_exp(tg_de, m_pol[2], m_run & m_sync),
                     line_exp(tg_vsync, m_pol[1], m_run & m_sync),
                     line_exp(tg_hsync, m_pol[0], m_run & m_sync)}));
            chk("R1 reg_rdata", reg_rdata, m_rd(reg_addr[3:2]));
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) tick();
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset fetch_en", 32'(fetch_en), 0);
        chk("R9 reset fetch_base", fetch_base, 0);
        chk("R9 reset irq/flush", 32'({frame_irq, fifo_flush}), 0);
        chk("R9 reset lcd lines", 32'({lcd_de, lcd_vsync, lcd_hsync}), 32'h7);
        chk("R9 reset ctrl", reg_rdata, 0);
        tick();
        // R2: all three bits in one write must not start
        wr(4'd0, 32'h7);
        @(negedge clk); chk("R2 run in same write", reg_rdata, 32'h6); tick();
        wr(4'd1, 32'h1);
        @(negedge clk); chk("R2 run after setup", 32'(fetch_en), 1); tick();
        // R1: write kinds on the next base
        wr(4'd8, 32'h1000);
        wr(4'd9, 32'h0234);
        wr(4'd10, 32'h0200);
        @(negedge clk); chk("R1 next kinds", reg_rdata, 32'h1034); tick();
        wr(4'd11, 32'hFFFF);
        @(negedge clk); chk("R1 kind 3 ignored", reg_rdata, 32'h1034); tick();
        // R5/R6: frame boundary swap and interrupt
        wr(4'd5, 32'h1);
        frame_end = 1'b1; tick(); frame_end = 1'b0;
        @(negedge clk);
        chk("R5 base swap", fetch_base, 32'h1034);
        chk("R6 irq raised", 32'(frame_irq), 1);
        tick();
        // R7: plain write leaves status, clear kind removes it
        wr(4'd4, 32'h0);
        @(negedge clk); chk("R7 plain keeps status", reg_rdata, 32'h2);
        chk("R6 irq masked", 32'(frame_irq), 0); tick();
        wr(4'd5, 32'h0);
        @(negedge clk); chk("R7 set no effect", reg_rdata, 32'h2); tick();
        wr(4'd6, 32'h2);
        @(negedge clk); chk("R7 clear", reg_rdata, 32'h0); tick();
        frame_end = 1'b1; wr(4'd6, 32'h2); frame_end = 1'b0;
        @(negedge clk); chk("R7 frame end wins", reg_rdata, 32'h2); tick();
        // R4: flush pulse
        wr(4'd1, 32'h8);
        @(negedge clk); chk("R4 flush pulse", 32'(fifo_flush), 1); tick();
        @(negedge clk); chk("R4 flush ends", 32'(fifo_flush), 0);
        reg_addr = 4'd0; #1 chk("R4 flush reads 0", 32'(reg_rdata[3]), 0); tick();
        // R3: plain write of run 0 ignored, then graceful drain
        wr(4'd0, 32'h6);
        @(negedge clk); chk("R3 write cannot stop", 32'(fetch_en), 1); tick();
        fifo_empty = 1'b0;
        wr(4'd2, 32'h2);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); chk("R3 runs while draining", 32'(fetch_en), 1); tick();
        end
        fifo_empty = 1'b1; tick();
        @(negedge clk); chk("R3 stops when empty", 32'(fetch_en), 0); tick();
        // R5: frame end ignored while stopped
        wr(4'd8, 32'hABCD);
        frame_end = 1'b1; tick(); frame_end = 1'b0;
        @(negedge clk); chk("R5 ignored when stopped", fetch_base, 32'h1034); tick();
        // R8: polarity and gating
        tg_hsync = 1'b1; reg_addr = 4'd0;
        @(negedge clk); chk("R8 inactive low-pol", 32'(lcd_hsync), 1); tick();
        wr(4'd1, 32'h10);
        @(negedge clk); chk("R8 inactive high-pol", 32'(lcd_hsync), 0); tick();
        wr(4'd1, 32'h2);
        wr(4'd1, 32'h1);
        @(negedge clk); chk("R8 active", 32'(lcd_hsync), 1); tick();
        wr(4'd2, 32'h4);
        @(negedge clk); chk("R8 sync off", 32'(lcd_hsync), 0); tick();
        // Mixed random traffic, compared against the model every cycle
        for (int c = 0; c < 3000; c++) begin
            reg_wr     = ($urandom % 3) == 0;
            reg_addr   = 4'($urandom);
            reg_wdata  = (reg_addr[3:2] == 2'd2) ? $urandom : ($urandom & 32'h7F);
            fifo_empty = ($urandom % 4) != 0;
            frame_end  = ($urandom % 8) == 0;
            {tg_de, tg_vsync, tg_hsync} = 3'($urandom);
            tick();
        end
        reg_wr = 1'b0; frame_end = 1'b0;
        tick();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule